// File: doc/BRIEF.md
# Shadow-Checked Register Bank with Timing-Error Recovery

This block is a bank of data flops in which every bit is watched by a second, later-sampling flop. The main flop captures the data input at the clock edge. The shadow flop samples the same data net at a later point in the same cycle. At the cycle level, that later point is modelled by a second input, `d_late`, which carries the value the net has settled to by the delayed sampling instant. Data that arrives late shows up as a difference between the two samples.

In the cycle after a capture, each bit compares its main and shadow copies. Any bit that differs is steered to the output from the shadow copy, so downstream logic sees the corrected word in that same cycle. One cycle later the block reports the error three ways: a registered per-bit error vector, an aggregated error flag and a one-cycle request to stretch the next clock period. At the same edge the corrected value is written back into the main flop, unless a new word is being captured at that edge. A saturating counter tallies the cycles in which an error was reported.

Top module: `shadow_check_reg`

## Requirements
- R1: While `rst_n` is low and after its release, `q_out`, `err_bits`, `err_any`, `stretch_req` and `err_count` are all zero.
- R2: A capture with both `cap_en` and `shadow_en` high and `d_late` equal to `d_in` puts `d_in` on `q_out` in the next cycle. No error is reported in the cycle after that.
- R3: When the two samples differ, `err_bits` has a 1 in exactly the bit positions where they differed. This appears in the cycle after the evaluation cycle, which is the cycle after capture.
- R4: During the evaluation cycle, `q_out` equals the shadow sample (`d_late`) in every bit.
- R5: `err_any` is high exactly when `err_bits` is non-zero.
- R6: `stretch_req` is high for exactly one cycle per evaluation cycle with a mismatch, aligned with `err_bits`. It is low after a clean evaluation.
- R7: If `cap_en` is low at the edge that ends the evaluation cycle, the main flop takes the corrected value, and `q_out` keeps showing the shadow sample afterwards.
- R8: If a new capture occurs at the edge that ends an evaluation cycle with a mismatch, the new word wins over write-back and appears on `q_out`. The error of the earlier word is still reported in `err_bits`.
- R9: A capture with `shadow_en` low performs no comparison. `q_out` shows `d_in`, no error is reported and `err_count` is unchanged.
- R10: `err_count` increases by one for each cycle in which `err_any` is high, and holds at its all-ones value once reached.
- R11: With `cap_en` low and no evaluation pending, `q_out` holds its value whatever `d_in` and `d_late` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; all flops update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Main flops capture `d_in` at this edge |
| shadow_en | input | 1 | Shadow flops capture `d_late` at this edge |
| d_in | input | WIDTH | Data as seen at the main sampling instant |
| d_late | input | WIDTH | Same data as seen at the delayed sampling instant |
| q_out | output | WIDTH | Register output, corrected bit-wise during evaluation |
| err_bits | output | WIDTH | Registered per-bit mismatch flags |
| err_any | output | 1 | OR of the registered per-bit flags |
| stretch_req | output | 1 | One-cycle request to lengthen the next clock period |
| err_count | output | CNT_W | Saturating count of error cycles |

## Verification
Two functions can land on the same edge: write-back of a corrected word and capture of the next word. The bench provokes this by raising `cap_en` with a clean new word in the evaluation cycle of a mismatching word. It then checks that `q_out` carries the new word and that `err_bits` still reports the old mismatch. A second coincidence is an error arriving while the counter is already saturated. This is driven by a long stream of mismatching captures, and the bench judges it by the count staying at all-ones while the error flags keep reporting.

// File: rtl/shadow_check_pkg.sv
package shadow_check_pkg;

  // Output steering: a flagged bit is taken from the shadow copy.
  function automatic logic steer_bit(input logic main_b, input logic shad_b, input logic flag);
    return flag ? shad_b : main_b;
  endfunction

  // Next main-flop value: a fresh capture beats write-back of the correction.
  function automatic logic main_next(input logic cap, input logic d,
                                     input logic flag, input logic shad_b, input logic main_b);
    if (cap) return d;
    if (flag) return shad_b;
    return main_b;
  endfunction

endpackage

// File: rtl/shadow_bit_cell.sv
module shadow_bit_cell
  import shadow_check_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic shd,
  input  logic chk,
  input  logic d,
  input  logic d_late,
  output logic q,
  output logic mis
);
  logic main_r;
  logic shad_r;

  assign mis = chk & (main_r ^ shad_r);
  assign q   = steer_bit(main_r, shad_r, mis);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_r <= 1'b0;
      shad_r <= 1'b0;
    end else begin
      main_r <= main_next(cap, d, mis, shad_r, main_r);
      if (shd) shad_r <= d_late;
    end
  end
endmodule

// File: rtl/shadow_err_collect.sv
module shadow_err_collect #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] mis_vec,
  output logic [WIDTH-1:0] err_bits,
  output logic             err_any,
  output logic             stretch_req,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c, input logic hit);
    if (!hit || c == CNT_MAX) return c;
    return c + 1'b1;
  endfunction

  logic hit;
  assign hit = |mis_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_bits    <= '0;
      err_any     <= 1'b0;
      stretch_req <= 1'b0;
      err_count   <= '0;
    end else begin
      err_bits    <= mis_vec;
      err_any     <= hit;
      stretch_req <= hit;
      err_count   <= sat_inc(err_count, hit);
    end
  end
endmodule

// File: rtl/shadow_check_reg.sv
module shadow_check_reg #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             shadow_en,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] d_late,
  output logic [WIDTH-1:0] q_out,
  output logic [WIDTH-1:0] err_bits,
  output logic             err_any,
  output logic             stretch_req,
  output logic [CNT_W-1:0] err_count
);
  // Evaluation cycle marker: both samples of one word are present.
  logic             chk_valid;
  logic [WIDTH-1:0] mis_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) chk_valid <= 1'b0;
    else        chk_valid <= cap_en & shadow_en;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    shadow_bit_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (cap_en),
      .shd    (shadow_en),
      .chk    (chk_valid),
      .d      (d_in[i]),
      .d_late (d_late[i]),
      .q      (q_out[i]),
      .mis    (mis_vec[i])
    );
  end

  shadow_err_collect #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .mis_vec     (mis_vec),
    .err_bits    (err_bits),
    .err_any     (err_any),
    .stretch_req (stretch_req),
    .err_count   (err_count)
  );
endmodule

// File: rtl/shadow_check_reg_sva.sv
module shadow_check_reg_sva #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic             shadow_en,
  input logic [WIDTH-1:0] q_out,
  input logic [WIDTH-1:0] err_bits,
  input logic             err_any,
  input logic             stretch_req,
  input logic [CNT_W-1:0] err_count,
  input logic             chk_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(!rst_n) |-> (err_bits == '0 && !err_any && !stretch_req));

  a_r3_err_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bits != '0) |-> $past(chk_valid));

  a_r5_any_tracks_bits: assert property (@(posedge clk) disable iff (!rst_n)
    err_any == (err_bits != '0));

  a_r6_stretch_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_req |-> ($past(chk_valid) && err_any));

  a_r9_no_check_without_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_en && !shadow_en) |-> !chk_valid);

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && $past(err_count) != CNT_MAX) |-> err_count == CNT_W'($past(err_count) + 1'b1));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_count) == CNT_MAX) |-> err_count == CNT_MAX);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cap_en) && !$past(chk_valid)) |-> $stable(q_out));
endmodule

bind shadow_check_reg shadow_check_reg_sva #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_en      (cap_en),
  .shadow_en   (shadow_en),
  .q_out       (q_out),
  .err_bits    (err_bits),
  .err_any     (err_any),
  .stretch_req (stretch_req),
  .err_count   (err_count),
  .chk_valid   (chk_valid)
);

// File: tb/shadow_check_reg_tb.sv
module shadow_check_reg_tb;
  localparam int W = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_en = 1'b0;
  logic shadow_en = 1'b0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] d_late = '0;
  logic [W-1:0] q_out;
  logic [W-1:0] err_bits;
  logic err_any;
  logic stretch_req;
  logic [CW-1:0] err_count;

  int n_chk = 0;
  int n_bad = 0;
  int cnt_exp = 0;

  always #2 clk = ~clk;

  shadow_check_reg #(.WIDTH(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shadow_en(shadow_en),
    .d_in(d_in), .d_late(d_late), .q_out(q_out), .err_bits(err_bits),
    .err_any(err_any), .stretch_req(stretch_req), .err_count(err_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cap_en = 1'b0; shadow_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 q_out", 32'(q_out), 0);
    check("R1 err_bits", 32'(err_bits), 0);
    check("R1 err_any", 32'(err_any), 0);
    check("R1 stretch", 32'(stretch_req), 0);
    check("R1 count", 32'(err_count), 0);
  endtask

  task automatic t_clean(input logic [W-1:0] w);
    cap_en = 1'b1; shadow_en = 1'b1; d_in = w; d_late = w;
    @(negedge clk); idle();
    check("R2 q_out eval", 32'(q_out), 32'(w));
    @(negedge clk);
    check("R2 no err_bits", 32'(err_bits), 0);
    check("R2 no stretch", 32'(stretch_req), 0);
    check("R2 q_out kept", 32'(q_out), 32'(w));
  endtask

  task automatic t_late(input logic [W-1:0] a, input logic [W-1:0] b);
    cap_en = 1'b1; shadow_en = 1'b1; d_in = a; d_late = b;
    @(negedge clk); idle(); d_in = ~a; d_late = ~a;
    check("R4 corrected q_out", 32'(q_out), 32'(b));
    @(negedge clk);
    if (cnt_exp < 255) cnt_exp++;
    check("R3 err_bits", 32'(err_bits), 32'(a ^ b));
    check("R5 err_any", 32'(err_any), 1);
    check("R6 stretch high", 32'(stretch_req), 1);
    check("R7 write-back", 32'(q_out), 32'(b));
    check("R10 count step", 32'(err_count), 32'(cnt_exp));
    @(negedge clk);
    check("R6 stretch drop", 32'(stretch_req), 0);
    check("R5 err_any drop", 32'(err_any), 0);
    check("R7 q_out after", 32'(q_out), 32'(b));
  endtask

  task automatic t_collide(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] nw);
    cap_en = 1'b1; shadow_en = 1'b1; d_in = a; d_late = b;
    @(negedge clk); d_in = nw; d_late = nw;
    check("R4 corrected before collision", 32'(q_out), 32'(b));
    @(negedge clk); idle();
    if (cnt_exp < 255) cnt_exp++;
    check("R8 new word wins", 32'(q_out), 32'(nw));
    check("R8 old error kept", 32'(err_bits), 32'(a ^ b));
    @(negedge clk);
    check("R8 clean follow-up", 32'(err_bits), 0);
    check("R8 q_out stays new", 32'(q_out), 32'(nw));
  endtask

  task automatic t_no_shadow(input logic [W-1:0] a);
    cap_en = 1'b1; shadow_en = 1'b0; d_in = a; d_late = ~a;
    @(negedge clk); idle();
    check("R9 q_out raw", 32'(q_out), 32'(a));
    @(negedge clk);
    check("R9 no err", 32'(err_any), 0);
    check("R9 count same", 32'(err_count), 32'(cnt_exp));
  endtask

  task automatic t_hold();
    logic [W-1:0] keep;
    keep = q_out;
    for (int i = 0; i < 4; i++) begin
      d_in = W'(i * 37 + 5); d_late = W'(i * 91 + 3);
      @(negedge clk);
    end
    check("R11 hold", 32'(q_out), 32'(keep));
  endtask

  task automatic t_saturate();
    cap_en = 1'b1; shadow_en = 1'b1; d_in = '0; d_late = 8'h81;
    for (int i = 0; i < 300; i++) @(negedge clk);
    cnt_exp = 255;
    check("R10 saturated", 32'(err_count), 255);
    check("R10 err still flagged", 32'(err_bits), 32'h81);
    @(negedge clk);
    check("R10 no wrap", 32'(err_count), 255);
    idle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean(8'hA5);
    t_clean(8'h3C);
    t_late(8'h00, 8'h01);
    t_late(8'hF0, 8'h0F);
    t_late(8'h55, 8'hD4);
    t_collide(8'h12, 8'h92, 8'h6E);
    t_no_shadow(8'h77);
    t_hold();
    t_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule